// File: doc/BRIEF.md
# All-Digital Phase-Locked Loop Core

This block locks a local square wave `u2` to a square-wave reference `u1`, both running near f0, where the single master clock runs at M times f0. The reference is compared with the local signal by an exclusive-OR detector. The detector output sets the direction of a wrap-around up/down counter that acts as the loop filter. When the counter wraps upward it emits a carry strobe. When it wraps downward it emits a borrow strobe.

Those strobes steer an increment/decrement pulse controller. The controller runs on a tick that is derived internally every H = M/(2N) master clocks. A carry moves the next controller pulse one tick earlier, and a borrow moves it one tick later. The controller pulses are divided by N to form `u2`. The loop settles where the detector output is a 50% square wave, which is when `u2` sits a quarter period from `u1`.

The span of the counter is chosen at run time by a 4-bit code, from 8 states up to 2^17 states. A short span acquires quickly but jitters. A long span filters noise but acquires slowly. To keep strobes quiet at lock, the span should exceed M/4. The reference `u1` is expected to be synchronous to the master clock.

Top module: `adpll_core`

## Requirements
- R1: `pd_out` equals `u1 XOR u2` as sampled at the previous master clock edge.
- R2: While enabled, the loop counter advances one step per master clock. It counts up when `pd_out` is 0 and down when it is 1. `carry` is high in the cycle where an up-counting counter is at or above its top value, and the counter then becomes 0. `borrow` is high in the cycle where a down-counting counter is at 0, and the counter then reloads the top value.
- R3: Span code c in 1..15 gives a top value of 2^(c+2)-1, so code 1 gives 7 and code 15 gives 131071. Code 0 falls back to top value 7. A new code takes effect for the counter one clock after it is applied.
- R4: While `en` is low, the counter is held at zero, and `carry` and `borrow` stay low.
- R5: The controller ticks every H = M/(2N) master clocks. When no strobes occur, `u2` is a square wave with a period of M master clocks (64 by default).
- R6: A strobe is latched until the next tick. At that tick, a pending carry alone makes the controller emit a pulse one tick early, and a pending borrow alone holds the next pulse back by one tick. Pending carry and borrow together cancel.
- R7: `u2` is the most significant bit of a modulo-N count of controller pulses.
- R8: With code 1 and `u1` at a period of 62 master clocks, within 80 reference periods `u2` rises as often as `u1` (within one edge) over a 20-period window, and `pd_out` is high for between 35% and 65% of that window.
- R9: During reset, `u2`, `pd_out`, `carry` and `borrow` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock at M times f0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop counter enable; low clears the counter and silences the strobes |
| span_code | input | 4 | Loop counter span selector |
| u1 | input | 1 | Reference square wave, synchronous to clk |
| u2 | output | 1 | Locally generated square wave |
| pd_out | output | 1 | Registered phase detector output |
| carry | output | 1 | Upward wrap strobe of the loop counter |
| borrow | output | 1 | Downward wrap strobe of the loop counter |

## Verification
The assertions check the local rules on every cycle:
- the detector output follows the previous XOR;
- after a carry the counter is zero, and after a borrow it holds the previous top value;
- an enabled up-count moves by exactly one;
- the top value is always one less than a power of two and follows the code;
- ticks never come back to back;
- a strobe stays pending until the next tick;
- `u2` changes only after a controller pulse.

Three matters only the bench's scenarios can show, by running its cycle model against the ports across code changes, enable drops and two reference frequencies. The first is the exact timing of insertions and deletions. The second is the free-running period of M clocks. The third is that the closed loop actually pulls into quadrature lock.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = (1 << CODE_W) + 1;

  function automatic logic [CNT_W-1:0] span_top(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] states;
    if (code == '0) states = (CNT_W+1)'(8);
    else            states = (CNT_W+1)'(4) << code;
    return CNT_W'(states - (CNT_W+1)'(1));
  endfunction

  function automatic int tick_ratio(input int m, input int n);
    return m / (2 * n);
  endfunction
endpackage

// File: rtl/adpll_phase_det.sv
module adpll_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic u1,
  input  logic u2,
  output logic pd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd <= 1'b0;
    else        pd <= u1 ^ u2;
  end
endmodule

// File: rtl/adpll_loop_filter.sv
module adpll_loop_filter
  import adpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              down,
  input  logic [CODE_W-1:0] code,
  output logic              carry,
  output logic              borrow
);
  logic [CNT_W-1:0] top_q;
  logic [CNT_W-1:0] cnt;
  logic             at_top;
  logic             at_zero;

  assign at_top  = (cnt >= top_q);
  assign at_zero = (cnt == '0);
  assign carry   = en & ~down & at_top;
  assign borrow  = en &  down & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= span_top('0);
      cnt   <= '0;
    end else begin
      top_q <= span_top(code);
      if (!en)       cnt <= '0;
      else if (!down) cnt <= at_top  ? '0    : cnt + CNT_W'(1);
      else            cnt <= at_zero ? top_q : cnt - CNT_W'(1);
    end
  end

  a_r2_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (cnt == '0));
  a_r2_borrow_reload: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |=> (cnt == $past(top_q)));
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && !carry) |=> (cnt == $past(cnt) + CNT_W'(1)));
  a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  a_r3_top_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot((CNT_W+1)'(top_q) + (CNT_W+1)'(1)));
  a_r3_top_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (top_q == span_top($past(code))));
endmodule

// File: rtl/adpll_idctl.sv
module adpll_idctl #(
  parameter int H = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pulse
);
  localparam int HC_W = (H > 1) ? $clog2(H) : 1;

  logic [HC_W-1:0] hcnt;
  logic            tick;
  logic            ins_p;
  logic            del_p;
  logic            ph;
  logic            eff_ins;
  logic            eff_del;

  assign tick    = (hcnt == HC_W'(H - 1));
  assign eff_ins = ins_p & ~del_p;
  assign eff_del = del_p & ~ins_p;
  assign pulse   = tick & (eff_ins | (~eff_del & ph));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      ins_p <= 1'b0;
      del_p <= 1'b0;
      ph    <= 1'b0;
    end else begin
      hcnt <= tick ? '0 : hcnt + HC_W'(1);
      if (tick) begin
        ins_p <= inc;
        del_p <= dec;
        if (!(eff_ins | eff_del)) ph <= ~ph;
      end else begin
        ins_p <= ins_p | inc;
        del_p <= del_p | dec;
      end
    end
  end

  generate
    if (H > 1) begin : g_gap
      a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    end
  endgenerate

  a_r6_inc_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !tick) |=> ins_p);
  a_r6_dec_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !tick) |=> del_p);
endmodule

// File: rtl/adpll_divn.sv
module adpll_divn #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic u2
);
  localparam int DIV_W = (N > 1) ? $clog2(N) : 1;

  logic [DIV_W-1:0] cnt;

  assign u2 = cnt[DIV_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + DIV_W'(1);
  end

  a_r7_edge_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (u2 != $past(u2)) |-> $past(step));
endmodule

// File: rtl/adpll_core.sv
module adpll_core
  import adpll_pkg::*;
#(
  parameter int M = 64,
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] span_code,
  input  logic              u1,
  output logic              u2,
  output logic              pd_out,
  output logic              carry,
  output logic              borrow
);
  localparam int H = tick_ratio(M, N);

  logic ctl_pulse;

  adpll_phase_det i_pd (
    .clk   (clk),
    .rst_n (rst_n),
    .u1    (u1),
    .u2    (u2),
    .pd    (pd_out)
  );

  adpll_loop_filter i_lf (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .down   (pd_out),
    .code   (span_code),
    .carry  (carry),
    .borrow (borrow)
  );

  adpll_idctl #(.H(H)) i_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (carry),
    .dec   (borrow),
    .pulse (ctl_pulse)
  );

  adpll_divn #(.N(N)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ctl_pulse),
    .u2    (u2)
  );

  a_r1_pd_is_xor: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pd_out == $past(u1 ^ u2)));
  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(carry || borrow));
endmodule

// File: tb/test_adpll_core.sv
`timescale 1ns/100ps
module test_adpll_core;
  localparam int M = 64;
  localparam int N = 8;
  localparam int H = M / (2 * N);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] code = 4'd1;
  logic       u1 = 1'b0;
  logic       u2, pd, carry, borrow;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int u1_period = 62;
  int u1_pos    = 0;
  bit model_on  = 1'b0;

  // behavioural model state
  int m_h, m_pd, m_top, m_cq, m_ins, m_del, m_ph, m_div;

  always #2.5 clk = ~clk;

  adpll_core #(.M(M), .N(N)) i_adpll_core (
    .clk(clk), .rst_n(rst_n), .en(en), .span_code(code), .u1(u1),
    .u2(u2), .pd_out(pd), .carry(carry), .borrow(borrow)
  );

  function automatic int top_for(int c);
    int states;
    if (c == 0) states = 8;
    else        states = 8 << (c - 1);
    return states - 1;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // reference square wave
  always @(posedge clk) begin
    #1;
    u1_pos = (u1_pos + 1) % u1_period;
    u1 = (u1_pos < u1_period / 2);
  end

  // cycle model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_pd = 0; m_top = 7; m_cq = 0;
      m_ins = 0; m_del = 0; m_ph = 0; m_div = 0;
    end else begin
      int tk, cy, bw, pl, ein, edl, nu2;
      tk = (m_h == H - 1);
      cy = en && !m_pd && (m_cq >= m_top);
      bw = en && m_pd && (m_cq == 0);
      nu2 = (m_div >= N / 2);
      ein = m_ins && !m_del;
      edl = m_del && !m_ins;
      pl = 0;
      if (tk) begin
        pl = ein || (!edl && m_ph);
        if (!(ein || edl)) m_ph = !m_ph;
        m_ins = cy;
        m_del = bw;
      end else begin
        m_ins = m_ins || cy;
        m_del = m_del || bw;
      end
      if (!en)        m_cq = 0;
      else if (!m_pd) m_cq = (m_cq >= m_top) ? 0 : m_cq + 1;
      else            m_cq = (m_cq == 0) ? m_top : m_cq - 1;
      m_top = top_for(code);
      m_pd  = u1 ^ nu2;
      m_div = (m_div + pl) % N;
      m_h   = (m_h + 1) % H;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      int e_u2, e_c, e_b;
      e_u2 = (m_div >= N / 2);
      e_c  = en && !m_pd && (m_cq >= m_top);
      e_b  = en && m_pd && (m_cq == 0);
      chk(u2 === e_u2[0], "R6 R7 u2 vs model", u2, e_u2);
      chk(pd === m_pd[0], "R1 pd_out vs model", pd, m_pd);
      chk(carry === e_c[0], "R2 R3 carry vs model", carry, e_c);
      chk(borrow === e_b[0], "R2 R3 borrow vs model", borrow, e_b);
      if (!en) chk(!carry && !borrow, "R4 strobes while disabled", carry | borrow, 0);
    end
  end

  initial begin
    int last_rise, prev_u2, rises_u2, rises_u1, prev_u1, pd_high, win;
    repeat (5) @(posedge clk);
    #1;
    chk(u2 == 0 && pd == 0 && carry == 0 && borrow == 0, "R9 reset outputs",
        {u2, pd, carry, borrow}, 0);
    rst_n = 1'b1;
    model_on = 1'b1;

    // free run with the loop counter disabled: R4, R5
    last_rise = -1;
    prev_u2 = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (u2 && !prev_u2) begin
        if (last_rise >= 0) chk(i - last_rise == M, "R5 free-run u2 period", i - last_rise, M);
        last_rise = i;
      end
      prev_u2 = u2;
    end

    // acquisition with the smallest span and a faster reference: R8
    @(posedge clk); #1;
    en = 1'b1; code = 4'd1;
    repeat (80 * 62) @(negedge clk);
    win = 20 * 62;
    rises_u2 = 0; rises_u1 = 0; pd_high = 0;
    prev_u2 = u2; prev_u1 = u1;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (u2 && !prev_u2) rises_u2++;
      if (u1 && !prev_u1) rises_u1++;
      if (pd) pd_high++;
      prev_u2 = u2; prev_u1 = u1;
    end
    chk((rises_u2 - rises_u1 <= 1) && (rises_u1 - rises_u2 <= 1), "R8 frequency lock",
        rises_u2, rises_u1);
    chk(pd_high * 100 >= win * 35 && pd_high * 100 <= win * 65, "R8 quadrature duty",
        pd_high, win / 2);

    // span changes, fallback code and an enable drop: R3, R4
    @(posedge clk); #1; code = 4'd0;
    repeat (1000) @(negedge clk);
    @(posedge clk); #1; code = 4'd3;
    repeat (1000) @(negedge clk);
    @(posedge clk); #1; code = 4'd15;
    repeat (500) @(negedge clk);
    @(posedge clk); #1; en = 1'b0;
    repeat (50) @(negedge clk);
    @(posedge clk); #1; en = 1'b1; code = 4'd2; u1_period = 66;
    repeat (3000) @(negedge clk);

    finish_run();
  end
endmodule